// File: doc/BRIEF.md
# MSI Capture Controller

This block sits on the inbound write path of a PCIe root port. Every memory write that arrives from the link is compared against a programmable 64-bit interrupt target address. A write that hits the target is consumed and treated as a message-signalled interrupt. Its data word names a vector, and the block records that vector as a pending bit in one of eight 32-bit status words. A write that misses the target is forwarded downstream, one cycle later and unchanged.

Software sees a small register window. It holds the two halves of the target address and, for each group of 32 vectors, an enable word, a mask word and a status word. Enable decides whether a vector may record at all. Mask only hides a recorded vector from the interrupt line. Status bits are cleared by writing ones to them. A single registered interrupt output is high while any group has a status bit that is set and not masked.

Top module: `msi_capture`

## Requirements
- R1: The target address low half is read and written at offset 0x820 and the high half at 0x824; both reset to zero and read back exactly what was written.
- R2: A write with `in_valid` high whose 64-bit address equals the target, and whose data value v is below 256, sets bit v%32 of the status word of group v/32 in the clock edge that accepts it.
- R3: Group g has its enable word at 0x828+12g, its mask word at 0x82C+12g and its status word at 0x830+12g. `reg_rdata` returns the addressed word one cycle after `reg_addr` is presented, and an unmapped offset reads as zero.
- R4: A vector whose enable bit is 0 records no status when its interrupt write arrives.
- R5: A matching write whose data is 256 or more changes no status bit. It is still consumed and not forwarded, and no lower data bits are used as an alias.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. A register write never sets a status bit.
- R7: When an interrupt write sets a status bit in the same cycle that a register write clears it, the bit ends up set; other bits cleared in that cycle are still cleared.
- R8: `irq_out` is registered: in each cycle it equals the OR over all groups of (status AND NOT mask) from the previous cycle. A masked vector still records status.
- R9: A write with `in_valid` high whose address differs from the target appears on `out_valid`/`out_addr`/`out_data` one cycle later with address and data unchanged; a matching write produces no `out_valid`.
- R10: After reset all enable, mask and status words and the target address are zero, and `irq_out` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound memory write present |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data (vector number for an interrupt write) |
| out_valid | output | 1 | Forwarded write present |
| out_addr | output | 64 | Forwarded write address |
| out_data | output | 32 | Forwarded write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A corrupt status, enable or mask bit shows at the ports in two ways. On `reg_rdata` it appears one cycle after the word is addressed. On `irq_out` it appears one cycle after the status changes, so every scenario reads back the exact status word it expects and times `irq_out` edge by edge. A wrong target compare shows at once as a write that is forwarded when it should be consumed, or the reverse, on the cycle after it is presented. Aliasing of out-of-range data, the set-over-clear priority and a bit landing in the wrong group each leave a status word that differs from the computed value.

// File: rtl/msi_capture_pkg.sv
package msi_capture_pkg;
  localparam int VEC_PER_GRP  = 32;
  localparam int OFF_TGT_LO   = 'h820;
  localparam int OFF_TGT_HI   = 'h824;
  localparam int OFF_GRP_EN   = 'h828;
  localparam int OFF_GRP_MASK = 'h82C;
  localparam int OFF_GRP_STAT = 'h830;
  localparam int GRP_STRIDE   = 12;
endpackage

// File: rtl/msi_target_match.sv
module msi_target_match
  import msi_capture_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int MADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               hit,
  output logic [MADDR_W-1:0] target,
  output logic               out_valid,
  output logic [MADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0]  out_data
);
  localparam logic [ADDR_W-1:0] LO_OFF = ADDR_W'(OFF_TGT_LO);
  localparam logic [ADDR_W-1:0] HI_OFF = ADDR_W'(OFF_TGT_HI);

  logic [DATA_W-1:0] tgt_lo_q, tgt_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == LO_OFF) tgt_lo_q <= reg_wdata;
      if (reg_addr == HI_OFF) tgt_hi_q <= reg_wdata;
    end
  end

  assign target = MADDR_W'({tgt_hi_q, tgt_lo_q});
  assign hit    = in_valid && (in_addr == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid && !hit;
      out_addr  <= in_addr;
      out_data  <= in_data;
    end
  end
endmodule

// File: rtl/msi_vector_bank.sv
module msi_vector_bank
  import msi_capture_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 8,
  parameter int GRP_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              vec_ok,
  input  logic [VEC_W-1:0]  vec,
  output logic [VEC_PER_GRP-1:0] en_o,
  output logic [VEC_PER_GRP-1:0] mask_o,
  output logic [VEC_PER_GRP-1:0] stat_o
);
  localparam int BIT_W = $clog2(VEC_PER_GRP);
  localparam int GSEL_W = VEC_W - BIT_W;
  localparam logic [ADDR_W-1:0] EN_OFF   = ADDR_W'(OFF_GRP_EN   + GRP_IDX*GRP_STRIDE);
  localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(OFF_GRP_MASK + GRP_IDX*GRP_STRIDE);
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(OFF_GRP_STAT + GRP_IDX*GRP_STRIDE);

  logic [VEC_PER_GRP-1:0] set_bits, clr_bits;
  logic                   grp_sel;

  assign grp_sel  = vec_ok && (vec[VEC_W-1:BIT_W] == GSEL_W'(GRP_IDX));
  assign set_bits = grp_sel ? ((VEC_PER_GRP'(1) << vec[BIT_W-1:0]) & en_o) : '0;
  assign clr_bits = (reg_wr && reg_addr == STAT_OFF) ? VEC_PER_GRP'(reg_wdata) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      mask_o <= '0;
      stat_o <= '0;
    end else begin
      if (reg_wr && reg_addr == EN_OFF)   en_o   <= VEC_PER_GRP'(reg_wdata);
      if (reg_wr && reg_addr == MASK_OFF) mask_o <= VEC_PER_GRP'(reg_wdata);
      stat_o <= (stat_o & ~clr_bits) | set_bits;
    end
  end
endmodule

// File: rtl/msi_capture.sv
module msi_capture
  import msi_capture_pkg::*;
#(
  parameter int NGROUPS = 8,
  parameter int ADDR_W  = 12,
  parameter int MADDR_W = 64,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_valid,
  output logic [MADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0]  out_data,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_out
);
  localparam int NVEC  = NGROUPS * VEC_PER_GRP;
  localparam int VEC_W = $clog2(NVEC);
  localparam int FLAT_W = NVEC;

  logic               hit;
  logic [MADDR_W-1:0] target;
  logic               vec_ok;
  logic [FLAT_W-1:0]  en_flat, mask_flat, stat_flat;
  logic [DATA_W-1:0]  rd_mux;

  msi_target_match #(
    .ADDR_W(ADDR_W), .MADDR_W(MADDR_W), .DATA_W(DATA_W)
  ) u_match (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .hit(hit), .target(target),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
  );

  assign vec_ok = hit && (in_data < DATA_W'(NVEC));

  for (genvar g = 0; g < NGROUPS; g++) begin : g_bank
    msi_vector_bank #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .GRP_IDX(g)
    ) u_bank (
      .clk(clk), .rst(rst),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .vec_ok(vec_ok), .vec(in_data[VEC_W-1:0]),
      .en_o(en_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .mask_o(mask_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .stat_o(stat_flat[g*VEC_PER_GRP +: VEC_PER_GRP])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFF_TGT_LO)) rd_mux = target[31:0];
    if (reg_addr == ADDR_W'(OFF_TGT_HI)) rd_mux = DATA_W'(target[MADDR_W-1:32]);
    for (int g = 0; g < NGROUPS; g++) begin
      if (reg_addr == ADDR_W'(OFF_GRP_EN + g*GRP_STRIDE))
        rd_mux = DATA_W'(en_flat[g*VEC_PER_GRP +: VEC_PER_GRP]);
      if (reg_addr == ADDR_W'(OFF_GRP_MASK + g*GRP_STRIDE))
        rd_mux = DATA_W'(mask_flat[g*VEC_PER_GRP +: VEC_PER_GRP]);
      if (reg_addr == ADDR_W'(OFF_GRP_STAT + g*GRP_STRIDE))
        rd_mux = DATA_W'(stat_flat[g*VEC_PER_GRP +: VEC_PER_GRP]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq_out   <= |(stat_flat & ~mask_flat);
    end
  end
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int FLAT_W  = 256,
  parameter int MADDR_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [MADDR_W-1:0] in_addr,
  input logic [MADDR_W-1:0] target,
  input logic               out_valid,
  input logic [MADDR_W-1:0] out_addr,
  input logic [FLAT_W-1:0]  en_flat,
  input logic [FLAT_W-1:0]  mask_flat,
  input logic [FLAT_W-1:0]  stat_flat,
  input logic               irq_out
);
  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_flat == '0 && en_flat == '0 && mask_flat == '0 && !irq_out && !out_valid));

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(stat_flat & ~mask_flat))));

  p_forward_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr != target) |=> (out_valid && out_addr == $past(in_addr)));

  p_consume_hit_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_addr == target) |=> !out_valid);

  p_enable_gate_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_flat & ~$past(stat_flat) & ~$past(en_flat)) == '0));

  p_single_set_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(stat_flat & ~$past(stat_flat)) <= 1));

  p_no_set_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ((stat_flat & ~$past(stat_flat)) == '0));
endmodule

bind msi_capture msi_capture_chk #(.FLAT_W(NVEC), .MADDR_W(MADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
  .target(target), .out_valid(out_valid), .out_addr(out_addr),
  .en_flat(en_flat), .mask_flat(mask_flat), .stat_flat(stat_flat),
  .irq_out(irq_out)
);

// File: tb/msi_capture_tb.sv
`timescale 1ns/1ps
module msi_capture_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic [31:0] out_data;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  localparam logic [63:0] TGT  = 64'h0000_0001_FEE0_1000;
  localparam logic [63:0] MISS = 64'h0000_0002_FEE0_1000;

  // {data[31:0], status offset[11:0], expected status word[31:0]}
  localparam logic [75:0] TBL [8] = '{
    {32'd0,   12'h830, 32'h0000_0001},
    {32'd31,  12'h830, 32'h8000_0000},
    {32'd32,  12'h83C, 32'h0000_0001},
    {32'd77,  12'h848, 32'h0000_2000},
    {32'd80,  12'h848, 32'h0000_0000},
    {32'd200, 12'h878, 32'h0000_0100},
    {32'd255, 12'h884, 32'h8000_0000},
    {32'd256, 12'h884, 32'h0000_0000}
  };

  always #2.5 clk = ~clk;

  msi_capture u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic send_wr(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int g = 0; g < 8; g++) reg_write(12'(12'h830 + 12*g), 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq_out after reset", 64'(irq_out), 64'd0);
    chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
    reg_read(12'h820, rd); chk("R10 target low reset", 64'(rd), 64'd0);
    reg_read(12'h830, rd); chk("R10 status reset", 64'(rd), 64'd0);

    // R1 target programming
    reg_write(12'h820, TGT[31:0]);
    reg_write(12'h824, TGT[63:32]);
    reg_read(12'h820, rd); chk("R1 target low readback", 64'(rd), 64'(TGT[31:0]));
    reg_read(12'h824, rd); chk("R1 target high readback", 64'(rd), 64'(TGT[63:32]));

    // enables: all on, group 2 only lower half
    for (int g = 0; g < 8; g++) reg_write(12'(12'h828 + 12*g), 32'hFFFF_FFFF);
    reg_write(12'h840, 32'h0000_FFFF);
    reg_read(12'h840, rd); chk("R3 group2 enable readback", 64'(rd), 64'h0000_FFFF);

    // table walk: R2 placement, R4 gating, R5 range
    for (int i = 0; i < 8; i++) begin
      clear_all();
      send_wr(TGT, TBL[i][75:44]);
      chk("R9 matching write not forwarded", 64'(out_valid), 64'd0);
      reg_read(TBL[i][43:32], rd);
      chk("R2/R4/R5 table status word", 64'(rd), 64'(TBL[i][31:0]));
    end

    // R5 no aliasing of low bits
    clear_all();
    send_wr(TGT, 32'h1000_0005);
    reg_read(12'h830, rd); chk("R5 out-of-range data no alias", 64'(rd), 64'd0);

    // R9 forwarding of a miss
    send_wr(MISS, 32'h0000_0007);
    chk("R9 miss forwarded valid", 64'(out_valid), 64'd1);
    chk("R9 miss forwarded addr", out_addr, MISS);
    chk("R9 miss forwarded data", 64'(out_data), 64'h7);
    reg_read(12'h830, rd); chk("R9 miss sets no status", 64'(rd), 64'd0);

    // R3 mask offset and unmapped read
    reg_write(12'h850, 32'hA5A5_0001);
    reg_read(12'h850, rd); chk("R3 group3 mask readback", 64'(rd), 64'hA5A5_0001);
    reg_write(12'h850, 32'h0);
    reg_read(12'h900, rd); chk("R3 unmapped reads zero", 64'(rd), 64'd0);

    // R8 mask behaviour and irq timing
    @(negedge clk);
    chk("R8 irq low with empty status", 64'(irq_out), 64'd0);
    reg_write(12'h82C, 32'h0000_0020);
    send_wr(TGT, 32'd5);
    reg_read(12'h830, rd); chk("R8 masked vector still records", 64'(rd), 64'h20);
    @(negedge clk);
    chk("R8 masked vector keeps irq low", 64'(irq_out), 64'd0);
    reg_write(12'h82C, 32'h0);
    chk("R8 irq not yet high same cycle as unmask", 64'(irq_out), 64'd0);
    @(negedge clk);
    chk("R8 irq high one cycle after unmask", 64'(irq_out), 64'd1);

    // R6 write-one-to-clear
    reg_write(12'h830, 32'h0);
    reg_read(12'h830, rd); chk("R6 writing zero keeps bit", 64'(rd), 64'h20);
    reg_write(12'h830, 32'h1);
    reg_read(12'h830, rd); chk("R6 register write never sets", 64'(rd), 64'h20);
    reg_write(12'h830, 32'h20);
    chk("R8 irq still high right after clear", 64'(irq_out), 64'd1);
    @(negedge clk);
    chk("R8 irq falls one cycle after clear", 64'(irq_out), 64'd0);
    reg_read(12'h830, rd); chk("R6 writing one clears", 64'(rd), 64'd0);

    // R7 set wins over simultaneous clear
    send_wr(TGT, 32'd3);
    send_wr(TGT, 32'd9);
    @(negedge clk);
    in_valid = 1'b1; in_addr = TGT; in_data = 32'd3;
    reg_wr = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h0000_0208;
    @(negedge clk);
    in_valid = 1'b0; reg_wr = 1'b0;
    reg_read(12'h830, rd); chk("R7 set wins, other clear applies", 64'(rd), 64'h8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule